// File: doc/BRIEF.md
# Integer and Single-Precision Float Conversion Unit

This block converts between 32-bit two's-complement integers and IEEE-754 binary32 values. One operation turns a signed integer into a float. The other turns a float into a signed integer. Each request carries an operation code, a 32-bit operand and a 2-bit rounding-mode field from the floating-point control register. A valid strobe qualifies the request. The result is registered and comes back one cycle later together with a done pulse.

Both conversion directions feed a single rounding-decision stage. The converter for the selected direction supplies four signals to that stage: the sign, the least significant kept bit, a guard bit and a sticky bit. The stage returns one increment bit. When a float-to-integer conversion gets a NaN, an infinity or a value outside the signed 32-bit range, the output saturates and a simple invalid status bit is raised with the result.

Top module: `fp_int_conv`

## Requirements
- R1: Operation code 0x04 converts `operand_i`, read as a signed 32-bit integer, to binary32. Every integer with magnitude up to 2^24 converts exactly, and integer 0 gives 0x00000000 (+0.0).
- R2: When an integer needs more than 24 significant bits, the dropped low bits are rounded under `rmode_i`. Code 0 rounds to nearest with ties to even. Code 1 rounds toward zero. Code 2 rounds toward +infinity. Code 3 rounds toward -infinity.
- R3: Operation code 0x05 converts a binary32 operand to a signed 32-bit integer. Any fraction is rounded under `rmode_i` using the same four codes as R2. For example, 2.5 gives 2 under code 0, and -0.5 gives -1 under code 3.
- R4: In float-to-integer conversion, a value above 2^31-1, a value below -2^31, an infinity or a NaN saturates by its sign bit. Sign 0 gives 0x7FFFFFFF and sign 1 gives 0x80000000. `invalid_o` is 1 with such a result.
- R5: `invalid_o` is 0 for every conversion whose result is in range, including an input of exactly -2^31 (0xCF000000), which gives 0x80000000.
- R6: A request accepted while `valid_i` is 1 has its result on `result_o` and a single-cycle `done_o` pulse at the next rising clock edge.
- R7: While `valid_i` is 0, or while it is 1 with an operation code other than 0x04 or 0x05, `done_o` stays 0 and `result_o` and `invalid_o` keep their previous values.
- R8: While `rst_ni` is low, `result_o` is 0, `done_o` is 0 and `invalid_o` is 0.
- R9: When rounding carries out of the 24-bit significand in integer-to-float conversion, the exponent goes up by one. For example, 0x01FFFFFF under code 0 gives 0x4C000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 8 | Operation code: 0x04 integer to float, 0x05 float to integer |
| operand_i | input | 32 | Source integer or binary32 value |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| result_o | output | 32 | Registered conversion result |
| done_o | output | 1 | One-cycle pulse marking a new result |
| invalid_o | output | 1 | Saturation status for the result on result_o |

## Verification
Every result, together with its invalid bit and done pulse, is due exactly one rising edge after the request. There is a single register stage between the operand and the outputs. The bench drives each request on a falling edge and samples the outputs on the next falling edge, once that single register has captured the result. On the falling edge after that, it checks that `done_o` has dropped and that the result has held, which shows the pulse lasts only one cycle.

// File: rtl/fpconv_pkg.sv
package fpconv_pkg;
  localparam int unsigned INT_W  = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned MAN_W  = 23;
  localparam int unsigned SIG_W  = MAN_W + 1;
  localparam int unsigned BIAS   = 127;
  localparam int unsigned LZ_W   = $clog2(INT_W);
  localparam int unsigned OP_W   = 8;

  localparam logic [OP_W-1:0] OP_I2F = 8'h04;
  localparam logic [OP_W-1:0] OP_F2I = 8'h05;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic sign;
    logic lsb;
    logic guard;
    logic sticky;
  } rnd_req_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [INT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        hit = 1'b1;
        n   = LZ_W'(INT_W - 1 - i);
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/fpconv_round.sv
module fpconv_round
  import fpconv_pkg::*;
(
  input  rnd_req_t   req_i,
  input  logic [1:0] rmode_i,
  output logic       inc_o
);
  logic lost;
  assign lost = req_i.guard | req_i.sticky;

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR: inc_o = req_i.guard & (req_i.sticky | req_i.lsb);
      RM_ZERO: inc_o = 1'b0;
      RM_UP:   inc_o = ~req_i.sign & lost;
      RM_DOWN: inc_o = req_i.sign & lost;
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpconv_i2f.sv
module fpconv_i2f
  import fpconv_pkg::*;
(
  input  logic [INT_W-1:0] int_i,
  input  logic             inc_i,
  output rnd_req_t         rnd_o,
  output logic [INT_W-1:0] flt_o
);
  localparam int unsigned LOW_W = INT_W - SIG_W; // bits below the kept significand

  logic             sgn;
  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lz;
  logic [INT_W-1:0] norm;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] exp_base;
  logic [EXP_W-1:0] exp_fin;
  logic [MAN_W-1:0] man_fin;

  assign sgn  = int_i[INT_W-1];
  assign mag  = sgn ? (~int_i + 1'b1) : int_i;
  assign lz   = lead_zeros(mag);
  assign norm = mag << lz;

  assign rnd_o.sign   = sgn;
  assign rnd_o.lsb    = norm[LOW_W];
  assign rnd_o.guard  = norm[LOW_W-1];
  assign rnd_o.sticky = |norm[LOW_W-2:0];

  assign exp_base = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);
  assign sum      = {1'b0, norm[INT_W-1:LOW_W]} + (SIG_W+1)'(inc_i);
  assign exp_fin  = exp_base + EXP_W'(sum[SIG_W]);
  assign man_fin  = sum[SIG_W] ? '0 : sum[MAN_W-1:0];

  assign flt_o = (mag == '0) ? '0 : {sgn, exp_fin, man_fin};
endmodule

// File: rtl/fpconv_f2i.sv
module fpconv_f2i
  import fpconv_pkg::*;
(
  input  logic [INT_W-1:0] flt_i,
  input  logic             inc_i,
  output rnd_req_t         rnd_o,
  output logic [INT_W-1:0] int_o,
  output logic             invalid_o
);
  localparam int unsigned        WIDE_W  = 2 * SIG_W + 2;
  localparam int unsigned        TAIL_W  = WIDE_W - SIG_W;
  localparam logic [EXP_W-1:0]   E_INT   = EXP_W'(BIAS + MAN_W);     // 2^23 scale
  localparam logic [EXP_W-1:0]   E_LIMIT = EXP_W'(BIAS + INT_W - 1); // 2^31 scale
  localparam logic [INT_W-1:0]   POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0]   NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic [SIG_W-1:0] sig;
  logic             too_big;
  logic             exact_min;
  logic [EXP_W-1:0] rsh;
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0] trunc;
  logic             g_bit;
  logic             s_bit;
  logic [INT_W-1:0] mag;

  assign sgn = flt_i[INT_W-1];
  assign ex  = flt_i[INT_W-2 -: EXP_W];
  assign fr  = flt_i[MAN_W-1:0];
  assign sig = {ex != '0, fr};

  assign too_big   = ex >= E_LIMIT;
  assign exact_min = sgn && (ex == E_LIMIT) && (fr == '0);
  assign rsh       = E_INT - ex;
  assign wide      = {sig, {TAIL_W{1'b0}}} >> rsh;

  always_comb begin
    if (ex >= E_INT) begin
      trunc = INT_W'(sig) << (ex - E_INT);
      g_bit = 1'b0;
      s_bit = 1'b0;
    end else if (rsh > EXP_W'(TAIL_W - 1)) begin
      trunc = '0;
      g_bit = 1'b0;
      s_bit = |sig;
    end else begin
      trunc = INT_W'(wide[WIDE_W-1:TAIL_W]);
      g_bit = wide[TAIL_W-1];
      s_bit = |wide[TAIL_W-2:0];
    end
  end

  assign rnd_o.sign   = sgn;
  assign rnd_o.lsb    = trunc[0];
  assign rnd_o.guard  = g_bit;
  assign rnd_o.sticky = s_bit;

  assign mag       = trunc + INT_W'(inc_i);
  assign invalid_o = too_big && !exact_min;

  always_comb begin
    if (invalid_o)      int_o = sgn ? NEG_SAT : POS_SAT;
    else if (exact_min) int_o = NEG_SAT;
    else                int_o = sgn ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/fp_int_conv.sv
module fp_int_conv
  import fpconv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       op_i,
  input  logic [31:0]      operand_i,
  input  logic [1:0]       rmode_i,
  output logic [31:0]      result_o,
  output logic             done_o,
  output logic             invalid_o
);
  logic             is_i2f;
  logic             is_f2i;
  logic             accept;
  rnd_req_t         rq_i2f;
  rnd_req_t         rq_f2i;
  rnd_req_t         rq_sel;
  logic             rnd_inc;
  logic [INT_W-1:0] res_i2f;
  logic [INT_W-1:0] res_f2i;
  logic             inv_f2i;

  assign is_i2f = op_i == OP_I2F;
  assign is_f2i = op_i == OP_F2I;
  assign accept = valid_i && (is_i2f || is_f2i);

  fpconv_i2f u_i2f (
    .int_i (operand_i),
    .inc_i (rnd_inc),
    .rnd_o (rq_i2f),
    .flt_o (res_i2f)
  );

  fpconv_f2i u_f2i (
    .flt_i     (operand_i),
    .inc_i     (rnd_inc),
    .rnd_o     (rq_f2i),
    .int_o     (res_f2i),
    .invalid_o (inv_f2i)
  );

  // one rounding decision serves whichever direction is selected
  assign rq_sel = is_i2f ? rq_i2f : rq_f2i;

  fpconv_round u_round (
    .req_i   (rq_sel),
    .rmode_i (rmode_i),
    .inc_o   (rnd_inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      done_o    <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      done_o <= accept;
      if (accept) begin
        result_o  <= is_i2f ? res_i2f : res_f2i;
        invalid_o <= is_f2i && inv_f2i;
      end
    end
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> done_o); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !done_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> ($stable(result_o) && $stable(invalid_o))); // R7
  AST_SAT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == 32'h7FFF_FFFF || result_o == 32'h8000_0000)); // R4
  AST_I2F_NEVER_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_i2f) |=> !invalid_o); // R5
endmodule

// File: tb/fp_int_conv_tb.sv
`timescale 1ns/1ps
module fp_int_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  op = '0;
  logic [31:0] operand = '0;
  logic [1:0]  rmode = '0;
  logic [31:0] result;
  logic        done;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fp_int_conv u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid),
    .op_i      (op),
    .operand_i (operand),
    .rmode_i   (rmode),
    .result_o  (result),
    .done_o    (done),
    .invalid_o (invalid)
  );

  // {op, operand, mode, expected result, expected invalid}
  localparam int NV = 41;
  localparam logic [74:0] VEC [NV] = '{
    {8'h04, 32'h0000_0001, 2'd0, 32'h3F80_0000, 1'b0},
    {8'h04, 32'hFFFF_FFFF, 2'd0, 32'hBF80_0000, 1'b0},
    {8'h04, 32'h0000_0000, 2'd2, 32'h0000_0000, 1'b0},
    {8'h04, 32'h0100_0000, 2'd1, 32'h4B80_0000, 1'b0},
    {8'h04, 32'h0100_0001, 2'd0, 32'h4B80_0000, 1'b0},
    {8'h04, 32'h0100_0001, 2'd1, 32'h4B80_0000, 1'b0},
    {8'h04, 32'h0100_0001, 2'd2, 32'h4B80_0001, 1'b0},
    {8'h04, 32'h0100_0001, 2'd3, 32'h4B80_0000, 1'b0},
    {8'h04, 32'hFEFF_FFFF, 2'd0, 32'hCB80_0000, 1'b0},
    {8'h04, 32'hFEFF_FFFF, 2'd2, 32'hCB80_0000, 1'b0},
    {8'h04, 32'hFEFF_FFFF, 2'd3, 32'hCB80_0001, 1'b0},
    {8'h04, 32'h0100_0003, 2'd0, 32'h4B80_0002, 1'b0},
    {8'h04, 32'h0100_0003, 2'd1, 32'h4B80_0001, 1'b0},
    {8'h04, 32'h01FF_FFFF, 2'd0, 32'h4C00_0000, 1'b0},
    {8'h04, 32'h01FF_FFFF, 2'd1, 32'h4BFF_FFFF, 1'b0},
    {8'h04, 32'h8000_0000, 2'd0, 32'hCF00_0000, 1'b0},
    {8'h04, 32'h7FFF_FFFF, 2'd0, 32'h4F00_0000, 1'b0},
    {8'h04, 32'h7FFF_FFFF, 2'd1, 32'h4EFF_FFFF, 1'b0},
    {8'h05, 32'h4020_0000, 2'd0, 32'h0000_0002, 1'b0},
    {8'h05, 32'h4020_0000, 2'd1, 32'h0000_0002, 1'b0},
    {8'h05, 32'h4020_0000, 2'd2, 32'h0000_0003, 1'b0},
    {8'h05, 32'h4020_0000, 2'd3, 32'h0000_0002, 1'b0},
    {8'h05, 32'h4060_0000, 2'd0, 32'h0000_0004, 1'b0},
    {8'h05, 32'hBF00_0000, 2'd0, 32'h0000_0000, 1'b0},
    {8'h05, 32'hBF00_0000, 2'd3, 32'hFFFF_FFFF, 1'b0},
    {8'h05, 32'hBF00_0000, 2'd2, 32'h0000_0000, 1'b0},
    {8'h05, 32'hC020_0000, 2'd0, 32'hFFFF_FFFE, 1'b0},
    {8'h05, 32'hC020_0000, 2'd3, 32'hFFFF_FFFD, 1'b0},
    {8'h05, 32'hC020_0000, 2'd2, 32'hFFFF_FFFE, 1'b0},
    {8'h05, 32'h3F80_0000, 2'd1, 32'h0000_0001, 1'b0},
    {8'h05, 32'h3F00_0001, 2'd0, 32'h0000_0001, 1'b0},
    {8'h05, 32'h0000_0001, 2'd2, 32'h0000_0001, 1'b0},
    {8'h05, 32'h0000_0001, 2'd0, 32'h0000_0000, 1'b0},
    {8'h05, 32'h8000_0000, 2'd3, 32'h0000_0000, 1'b0},
    {8'h05, 32'h4EFF_FFFF, 2'd0, 32'h7FFF_FF80, 1'b0},
    {8'h05, 32'hCF00_0000, 2'd0, 32'h8000_0000, 1'b0},
    {8'h05, 32'h4F00_0000, 2'd0, 32'h7FFF_FFFF, 1'b1},
    {8'h05, 32'hCF00_0001, 2'd1, 32'h8000_0000, 1'b1},
    {8'h05, 32'h7FC0_0000, 2'd0, 32'h7FFF_FFFF, 1'b1},
    {8'h05, 32'hFF80_0000, 2'd0, 32'h8000_0000, 1'b1},
    {8'h05, 32'h7F80_0000, 2'd2, 32'h7FFF_FFFF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive one request on a falling edge, sample on the next falling edge
  task automatic issue(input logic [7:0] o, input logic [31:0] a, input logic [1:0] m);
    op = o; operand = a; rmode = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    @(negedge clk);
    @(negedge clk);
    // R8 reset state
    check("R8 result", result, 32'h0);
    check("R8 done", {31'b0, done}, 32'h0);
    check("R8 invalid", {31'b0, invalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      string tag;
      v = VEC[i];
      tag = (v[74:67] == 8'h04) ? "R1 R2 R9" : "R3 R4 R5";
      issue(v[74:67], v[66:35], v[34:33]);
      check(tag, result, v[32:1]);
      check({tag, " invalid"}, {31'b0, invalid}, {31'b0, v[0]});
      check("R6 done", {31'b0, done}, 32'h1);
      held = result;
      @(negedge clk);
      check("R6 pulse", {31'b0, done}, 32'h0);
      check("R7 hold idle", result, held);
    end

    // R7 unsupported opcode: no done, result and status untouched
    issue(8'h05, 32'h4F00_0000, 2'd0);
    held = result;
    issue(8'h06, 32'h3F80_0000, 2'd0);
    check("R7 bad op done", {31'b0, done}, 32'h0);
    check("R7 bad op result", result, held);
    check("R7 bad op invalid", {31'b0, invalid}, 32'h1);

    // R7 valid low with a legal opcode
    op = 8'h04; operand = 32'h0000_0005; rmode = 2'd0;
    @(negedge clk);
    check("R7 no valid done", {31'b0, done}, 32'h0);
    check("R7 no valid result", result, held);

    // R6 back-to-back requests each produce their own result
    op = 8'h04; operand = 32'h0000_0002; valid = 1'b1;
    @(negedge clk);
    check("R6 b2b first", result, 32'h4000_0000);
    check("R5 b2b invalid clear", {31'b0, invalid}, 32'h0);
    op = 8'h05; operand = 32'h4040_0000;
    @(negedge clk);
    valid = 1'b0;
    check("R6 b2b second", result, 32'h0000_0003);
    check("R6 b2b done", {31'b0, done}, 32'h1);

    // R8 asynchronous reset clears outputs
    #1 rst_n = 1'b0;
    #1;
    check("R8 async result", result, 32'h0);
    check("R8 async done", {31'b0, done}, 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule